// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block is the system-wide interrupt router. Thirty-two level-sensitive source lines are sampled every clock. Each source owns a bit in a pending register and a bit in a disable mask, and each source maps through a fixed table to a priority level between 0 and 15. Sources mapped to level 0 are dead and never become pending. From the pending sources that are not disabled, the block finds the highest level and presents it as an interrupt request to one selected target processor. The request is held off while that processor reports an interrupt already in service.

Every edge on a live source line also produces a one-cycle strobe to the per-processor register banks, which sit outside this block. The strobe carries the current target index, the source's level and whether the level bit is to be set (rising edge) or cleared (falling edge). When several source lines change in the same cycle, the edges are handled one per clock, lowest source index first.

Software uses a small register window of 32 bytes. It can read the pending and disable registers, clear disable bits through an enable word, set disable bits and drop the matching pending bits through a disable word, and read or write the target processor index.

Top module: `sysirq_router`

## Requirements
- R1: After reset the pending register reads 0, the disable register reads 0x004DFF80, the target index reads 0, and no request is raised.
- R2: The level table for sources 0 to 31 is 2,3,5,7,9,11,0,14,3,5,7,9,11,13,12,12,6,0,4,10,8,0,11,0,0,0,0,0,15,0,15,0. `irqLevel` is the largest table level among the pending sources that are not disabled. It is 0 when no such source exists or when bit 31 of the disable register is set.
- R3: `irqReq` is high exactly when at least one pending source is not disabled, bit 31 of the disable register is clear and `cpuBusy` is low.
- R4: A write to byte offset 0x08 clears the disable bits given by the write data. Bits set in 0x4FB2007F are removed from the data first, so those disable bits keep their value.
- R5: A write to byte offset 0x0C sets the given disable bits and clears the same pending bits, with the same reserved-bit mask as R4. A pending bit cleared this way stays clear until the next rising edge of its source.
- R6: Byte offset 0x10 is the target index. A write keeps only data bits [3:0], and a read returns that value. Offset 0x00 reads the pending register with bit 31 forced to 0, and offset 0x04 reads the disable register. Every other offset reads 0 and ignores writes.
- R7: A rising edge on a source with a nonzero level sets its pending bit, and a falling edge clears it. Sources with level 0 never set a pending bit and never cause a strobe.
- R8: Each handled edge gives one cycle of `bankStb`, in the same cycle the edge is first seen at the input. The strobe carries `bankTarget` (the target index before that clock edge), `bankLevel` (the source's level) and `bankSet` (1 for a rise, 0 for a fall). Edges that appear together are handled one per cycle in ascending source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLines | input | 32 | Level-sensitive interrupt source lines |
| cpuBusy | input | 1 | Target processor already has an interrupt in service |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte offset in the register window |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for `busAddr` (combinational) |
| irqReq | output | 1 | Interrupt request to the target processor |
| irqLevel | output | 4 | Highest enabled pending level |
| irqTarget | output | 4 | Target processor index |
| bankStb | output | 1 | Strobe to the per-processor banks, one per handled edge |
| bankTarget | output | 4 | Processor whose bank is updated |
| bankLevel | output | 4 | Level bit to update |
| bankSet | output | 1 | 1 sets the level bit, 0 clears it |

## Verification
The assertions check on every cycle that level-0 sources never hold a pending bit and that a strobe never carries level 0. They also check that a disable write leaves its bits clear in the pending register, that the reserved disable bits survive an enable write, that a handled rise leaves its pending bit set, and that a raised request always carries a nonzero level. Only the bench scenarios can show that the chosen level matches the mapping table, that the master disable and `cpuBusy` gate the request, how the register window reads back, and that edges appearing together are strobed in ascending index order with the right target.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;

  localparam int SRC_N   = 32;
  localparam int LVL_W   = 4;
  localparam int IDX_W   = $clog2(SRC_N);
  localparam int DATA_W  = 32;

  // Level per source, source 0 in the lowest nibble.
  localparam logic [SRC_N*LVL_W-1:0] LVL_TABLE =
    128'h0F0F_0000_0B08_A406_CCDB_9753_E0B9_7532;

  // Disable bits that software writes may not touch.
  localparam logic [DATA_W-1:0] RSV_MASK   = 32'h4FB2_007F;
  localparam logic [DATA_W-1:0] DIS_RESET  = ~32'hFFB2_007F;

  function automatic logic [LVL_W-1:0] lvlOf(input int idx);
    return LVL_TABLE[idx*LVL_W +: LVL_W];
  endfunction

  function automatic logic [SRC_N-1:0] levelMask(input int lvl);
    logic [SRC_N-1:0] m;
    for (int i = 0; i < SRC_N; i++) m[i] = (int'(lvlOf(i)) == lvl);
    return m;
  endfunction

  function automatic logic [SRC_N-1:0] liveMask();
    logic [SRC_N-1:0] m;
    for (int i = 0; i < SRC_N; i++) m[i] = (lvlOf(i) != '0);
    return m;
  endfunction

  typedef struct packed {
    logic              enWr;
    logic              disWr;
    logic              tgtWr;
    logic [DATA_W-1:0] wdata;
    logic              srcUpd;
    logic              srcVal;
    logic [IDX_W-1:0]  srcIdx;
  } ctlStb_t;

endpackage

// File: rtl/sysirq_ctrl.sv
module sysirq_ctrl
  import sysirq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcLines,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStb_t           ctl
);

  localparam logic [SRC_N-1:0] LIVE = liveMask();
  localparam int WORD_W = ADDR_W - 2;

  logic [SRC_N-1:0] srcQ;
  logic [SRC_N-1:0] liveDiff;
  logic [SRC_N-1:0] srcQNext;
  logic             found;
  logic [IDX_W-1:0] pickIdx;
  logic [WORD_W-1:0] wordSel;

  assign wordSel  = busAddr[ADDR_W-1:2];
  assign liveDiff = (srcLines ^ srcQ) & LIVE;

  // Lowest-index changed live source wins this cycle.
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (liveDiff[i]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    srcQNext = (srcQ & LIVE) | (srcLines & ~LIVE);
    if (found) srcQNext[pickIdx] = srcLines[pickIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= '0;
    else       srcQ <= srcQNext;
  end

  always_comb begin
    ctl        = '0;
    ctl.wdata  = busWdata;
    ctl.enWr   = busWr && (wordSel == WORD_W'(2));
    ctl.disWr  = busWr && (wordSel == WORD_W'(3));
    ctl.tgtWr  = busWr && (wordSel == WORD_W'(4));
    ctl.srcUpd = found;
    ctl.srcIdx = pickIdx;
    ctl.srcVal = srcLines[pickIdx];
  end

  AST_STB_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.srcUpd |-> LIVE[ctl.srcIdx]); // R7

  AST_EDGE_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.srcUpd |=> srcQ[$past(ctl.srcIdx)] == $past(ctl.srcVal)); // R8

endmodule

// File: rtl/sysirq_dp.sv
module sysirq_dp
  import sysirq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int TGT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              cpuBusy,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic [LVL_W-1:0]  irqLevel,
  output logic [TGT_W-1:0]  irqTarget,
  output logic              bankStb,
  output logic [TGT_W-1:0]  bankTarget,
  output logic [LVL_W-1:0]  bankLevel,
  output logic              bankSet
);

  localparam int LVL_N  = 1 << LVL_W;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [SRC_N-1:0] DEAD = ~liveMask();
  localparam logic [DATA_W-1:0] WMASK = ~RSV_MASK;

  logic [SRC_N-1:0]  pendR;
  logic [DATA_W-1:0] disR;
  logic [TGT_W-1:0]  tgtR;
  logic [SRC_N-1:0]  pendNext;
  logic [DATA_W-1:0] disNext;
  logic [DATA_W-1:0] wMasked;
  logic [SRC_N-1:0]  enPend;
  logic [LVL_N-1:0]  lvlHit;
  logic [LVL_W-1:0]  maxLvl;
  logic              masterOff;
  logic [WORD_W-1:0] wordSel;

  assign wMasked   = ctl.wdata & WMASK;
  assign masterOff = disR[DATA_W-1];
  assign enPend    = pendR & ~disR[SRC_N-1:0];

  always_comb begin
    pendNext = pendR;
    if (ctl.srcUpd) pendNext[ctl.srcIdx] = ctl.srcVal;
    if (ctl.disWr)  pendNext = pendNext & ~wMasked[SRC_N-1:0];
  end

  always_comb begin
    disNext = disR;
    if (ctl.enWr)  disNext = disNext & ~wMasked;
    if (ctl.disWr) disNext = disNext | wMasked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendR <= '0;
      disR  <= DIS_RESET;
      tgtR  <= '0;
    end else begin
      pendR <= pendNext;
      disR  <= disNext;
      if (ctl.tgtWr) tgtR <= ctl.wdata[TGT_W-1:0];
    end
  end

  // One OR-reduction per level, then a priority pick of the top level.
  assign lvlHit[0] = 1'b0;
  for (genvar l = 1; l < LVL_N; l++) begin : g_lvl
    localparam logic [SRC_N-1:0] LMASK = levelMask(l);
    assign lvlHit[l] = |(enPend & LMASK);
  end

  always_comb begin
    maxLvl = '0;
    for (int l = 1; l < LVL_N; l++)
      if (lvlHit[l]) maxLvl = LVL_W'(l);
  end

  assign irqLevel  = masterOff ? '0 : maxLvl;
  assign irqReq    = (|enPend) && !masterOff && !cpuBusy;
  assign irqTarget = tgtR;

  assign bankStb    = ctl.srcUpd;
  assign bankTarget = tgtR;
  assign bankLevel  = lvlOf(int'(ctl.srcIdx));
  assign bankSet    = ctl.srcVal;

  assign wordSel = busAddr[ADDR_W-1:2];
  always_comb begin
    case (wordSel)
      WORD_W'(0): busRdata = {1'b0, pendR[SRC_N-2:0]};
      WORD_W'(1): busRdata = disR;
      WORD_W'(4): busRdata = DATA_W'(tgtR);
      default:    busRdata = '0;
    endcase
  end

  AST_DEAD_NEVER_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (pendR & DEAD) == '0); // R7

  AST_DIS_DROPS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.disWr |=> (pendR & $past(wMasked[SRC_N-1:0])) == '0); // R5

  AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enWr |=> (disR & RSV_MASK) == ($past(disR) & RSV_MASK)); // R4

  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.srcUpd && ctl.srcVal && !ctl.disWr) |=> pendR[$past(ctl.srcIdx)]); // R7

  AST_REQ_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqLevel != '0); // R3

  AST_STB_LEVEL_NZ: assert property (@(posedge clk) disable iff (!rstN)
    bankStb |-> bankLevel != '0); // R8

endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
  import sysirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int TGT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       srcLines,
  input  logic              cpuBusy,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqReq,
  output logic [3:0]        irqLevel,
  output logic [TGT_W-1:0]  irqTarget,
  output logic              bankStb,
  output logic [TGT_W-1:0]  bankTarget,
  output logic [3:0]        bankLevel,
  output logic              bankSet
);

  ctlStb_t ctl;

  sysirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcLines (srcLines),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .ctl      (ctl)
  );

  sysirq_dp #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busAddr    (busAddr),
    .cpuBusy    (cpuBusy),
    .busRdata   (busRdata),
    .irqReq     (irqReq),
    .irqLevel   (irqLevel),
    .irqTarget  (irqTarget),
    .bankStb    (bankStb),
    .bankTarget (bankTarget),
    .bankLevel  (bankLevel),
    .bankSet    (bankSet)
  );

endmodule

// File: tb/sim_sysirq_router.sv
module sim_sysirq_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcLines = '0;
  logic        cpuBusy = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqReq;
  logic [3:0]  irqLevel;
  logic [3:0]  irqTarget;
  logic        bankStb;
  logic [3:0]  bankTarget;
  logic [3:0]  bankLevel;
  logic        bankSet;

  int nRun  = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  sysirq_router u0 (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .cpuBusy(cpuBusy),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqTarget(irqTarget),
    .bankStb(bankStb), .bankTarget(bankTarget), .bankLevel(bankLevel),
    .bankSet(bankSet)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic        busy;
    logic        expReq;
    logic [3:0]  expLvl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 32'h0,        32'h0000_0001, 1'b0, 1'b1, 4'd2},  // R2 single source
    '{1'b0, 5'h00, 32'h0,        32'h0000_0009, 1'b0, 1'b1, 4'd7},  // R2 max of two
    '{1'b0, 5'h00, 32'h0,        32'h0000_0089, 1'b0, 1'b1, 4'd7},  // R2 disabled source ignored
    '{1'b1, 5'h08, 32'h0000_0080,32'h0000_0089, 1'b0, 1'b1, 4'd14}, // R4 enable bit 7
    '{1'b0, 5'h00, 32'h0,        32'h1000_0089, 1'b0, 1'b1, 4'd15}, // R2 level 15
    '{1'b1, 5'h0C, 32'h1000_0000,32'h1000_0089, 1'b0, 1'b1, 4'd14}, // R5 disable drops pending
    '{1'b1, 5'h0C, 32'h8000_0000,32'h1000_0089, 1'b0, 1'b0, 4'd0},  // R3 master off
    '{1'b1, 5'h08, 32'h8000_0000,32'h1000_0089, 1'b0, 1'b1, 4'd14}, // R3 master on
    '{1'b0, 5'h00, 32'h0,        32'h1000_0089, 1'b1, 1'b0, 4'd14}, // R3 busy
    '{1'b0, 5'h00, 32'h0,        32'h1000_0009, 1'b0, 1'b1, 4'd7},  // R7 fall clears
    '{1'b1, 5'h08, 32'h0000_007F,32'h1000_0009, 1'b0, 1'b1, 4'd7},  // R4 reserved enable bits
    '{1'b1, 5'h0C, 32'h0000_000F,32'h1000_0009, 1'b0, 1'b1, 4'd7},  // R5 reserved disable bits
    '{1'b0, 5'h00, 32'h0,        32'h0000_0040, 1'b0, 1'b0, 4'd0}   // R7 level-0 source
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 req", {31'b0, irqReq}, 32'h0);
    rdChk("R1 pending", 5'h00, 32'h0);
    rdChk("R1 disable", 5'h04, 32'h004D_FF80);
    rdChk("R1 target", 5'h10, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      srcLines = VEC[v].src;
      cpuBusy  = VEC[v].busy;
      busWr    = VEC[v].wr;
      busAddr  = VEC[v].addr;
      busWdata = VEC[v].data;
      @(negedge clk);
      busWr = 1'b0;
      repeat (4) tick();
      chk($sformatf("R3 vec%0d req", v), {31'b0, irqReq}, {31'b0, VEC[v].expReq});
      chk($sformatf("R2 vec%0d level", v), {28'b0, irqLevel}, {28'b0, VEC[v].expLvl});
    end
    rdChk("R7 level-0 source not pending", 5'h00, 32'h0);
    rdChk("R4 R5 disable after writes", 5'h04, 32'h104D_FF00);

    // Reset again mid-run.
    @(negedge clk);
    srcLines = '0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    rdChk("R1 disable after reset", 5'h04, 32'h004D_FF80);
    rdChk("R6 unused offset", 5'h14, 32'h0);

    // Target register keeps 4 bits.
    wrReg(5'h10, 32'h0000_0035);
    rdChk("R6 target 4 bits", 5'h10, 32'h5);
    chk("R6 irqTarget", {28'b0, irqTarget}, 32'h5);
    wrReg(5'h18, 32'hFFFF_FFFF);
    rdChk("R6 write to unused offset ignored", 5'h04, 32'h004D_FF80);

    // Single rising edge strobe.
    @(negedge clk);
    srcLines = 32'h0000_0002;
    #1;
    chk("R8 strobe", {31'b0, bankStb}, 32'h1);
    chk("R8 target", {28'b0, bankTarget}, 32'h5);
    chk("R8 level", {28'b0, bankLevel}, 32'h3);
    chk("R8 set", {31'b0, bankSet}, 32'h1);
    tick();
    chk("R8 single strobe", {31'b0, bankStb}, 32'h0);
    rdChk("R7 rise sets pending", 5'h00, 32'h0000_0002);

    // Three edges together, served in ascending index order.
    @(negedge clk);
    srcLines = 32'h0000_0011;
    #1;
    chk("R8 first idx0 level", {28'b0, bankLevel}, 32'h2);
    chk("R8 first idx0 set", {31'b0, bankSet}, 32'h1);
    @(negedge clk);
    chk("R8 second idx1 level", {28'b0, bankLevel}, 32'h3);
    chk("R8 second idx1 clear", {31'b0, bankSet}, 32'h0);
    @(negedge clk);
    chk("R8 third idx4 level", {28'b0, bankLevel}, 32'h9);
    chk("R8 third idx4 set", {31'b0, bankSet}, 32'h1);
    chk("R8 third strobe", {31'b0, bankStb}, 32'h1);
    @(negedge clk);
    chk("R8 idle after edges", {31'b0, bankStb}, 32'h0);
    rdChk("R7 pending after edges", 5'h00, 32'h0000_0011);
    chk("R2 level after edges", {28'b0, irqLevel}, 32'h9);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule